// File: doc/BRIEF.md
# GPIO Interrupt Event Controller

This block watches 32 GPIO line inputs, which arrive already synchronized to the local clock. It turns selected transitions on those lines into latched interrupt events. Each line has a pending bit that is set when its chosen edge is seen. Software clears a pending bit by writing a one to it. A mask register decides which pending bits reach the single interrupt output. Software reaches the block through a small 32-bit register port: a write strobe, a byte address, write data, and combinational read data.

Line numbering is mirrored in every per-line register: line n lives at bit 31 − n. A build-time parameter picks one of two edge-control formats:

- **One-bit format:** one control register with one bit per line, choosing "falling only" or "both edges".
- **Two-bit format:** two control registers with a two-bit code per line. The first register covers lines 0–15 and the second covers lines 16–31.

Top module: `gpio_evt_ctrl`

## Requirements
- R1: After reset, the event, mask and control registers read 0 and `irq` is low.
- R2: Line n sets bit (31 − n) of the event register, and bit (31 − n) of the mask register gates that line.
- R3: A write to offset 0x0C clears each event bit whose write-data bit is 1. Bits written with 0 keep their value.
- R4: If a detected edge and a clearing write hit the same event bit in the same cycle, the bit is set afterwards.
- R5: `irq` is high exactly when some bit of (event AND mask) is 1. Events latch whatever the mask, so unmasking a pending line raises `irq` right after the mask write.
- R6: In one-bit format (TWO_BIT_MODE=0), control bit (31 − n) at offset 0x14 set to 1 makes line n record only falling edges. Set to 0, it records both rising and falling edges.
- R7: In two-bit format (TWO_BIT_MODE=1), line n reads a code from offset 0x14 for n<16 and from offset 0x18 for n≥16. The code sits at bit offset (15 − (n mod 16))×2. Code 0 records both edges, 1 rising only, 2 falling only, and 3 nothing.
- R8: Offsets are 0x0C event, 0x10 mask, 0x14 first control, 0x18 second control. Written values read back at their own offsets. In one-bit format, 0x18 reads 0 and writes to it are ignored. Other offsets read 0.
- R9: An edge is a difference between a line's input and its value on the previous cycle. An input change before clock edge k shows in the event register after edge k. No edge is seen on the first cycle after reset, so lines already high at reset do not raise events.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 32 | Synchronized GPIO line levels, index = line number |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Combined interrupt request |

## Verification
Timing of each result after its stimulus:

- **Line change:** a change applied between clock edges sets its event bit at the next rising edge.
- **Register write:** a write held across one rising edge takes effect at that edge, and `irq` follows in the same cycle, since it is a combinational function of registers.
- **Read:** `rd_data` is combinational and reflects the current registers without delay.

The bench drives every stimulus on the falling edge and samples one falling edge later, exactly one register stage downstream. It sweeps all 32 lines over every edge setting in both formats, with one instance of each format.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  localparam int REG_W   = 32;
  localparam int ADDR_W  = 8;
  localparam int HALF    = REG_W / 2;
  localparam int CODE_W  = 2;

  localparam logic [ADDR_W-1:0] OFS_EVT   = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_CTL_A = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_CTL_B = 8'h18;

  typedef enum logic [CODE_W-1:0] {
    EDGE_BOTH = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_OFF  = 2'd3
  } edge_sel_e;

  // register bit that carries a given line (mirrored order)
  function automatic int line_bit(int n);
    return REG_W - 1 - n;
  endfunction

  // lsb of the two-bit code for a line within its control register
  function automatic int field_lsb(int n);
    return (HALF - 1 - (n % HALF)) * CODE_W;
  endfunction

  function automatic logic edge_hit(edge_sel_e s, logic rise, logic fall);
    case (s)
      EDGE_BOTH: return rise | fall;
      EDGE_RISE: return rise;
      EDGE_FALL: return fall;
      default:   return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/gpio_evt_regs.sv
module gpio_evt_regs
  import gpio_evt_pkg::*;
#(
  parameter bit TWO_BIT_MODE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [REG_W-1:0]  pend,
  output logic [REG_W-1:0]  mask,
  output logic [REG_W-1:0]  ctl_a,
  output logic [REG_W-1:0]  ctl_b,
  output logic [REG_W-1:0]  clr_vec,
  output logic [REG_W-1:0]  rd_data
);
  assign clr_vec = (wr_en && addr == OFS_EVT) ? wr_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask  <= '0;
      ctl_a <= '0;
    end else if (wr_en) begin
      if (addr == OFS_MASK)  mask  <= wr_data;
      if (addr == OFS_CTL_A) ctl_a <= wr_data;
    end
  end

  generate
    if (TWO_BIT_MODE) begin : g_ctl_b
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            ctl_b <= '0;
        else if (wr_en && addr == OFS_CTL_B)   ctl_b <= wr_data;
      end
    end else begin : g_no_ctl_b
      assign ctl_b = '0;
    end
  endgenerate

  always_comb begin
    case (addr)
      OFS_EVT:   rd_data = pend;
      OFS_MASK:  rd_data = mask;
      OFS_CTL_A: rd_data = ctl_a;
      OFS_CTL_B: rd_data = ctl_b;
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
  import gpio_evt_pkg::*;
#(
  parameter bit TWO_BIT_MODE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] line_in,
  input  logic [REG_W-1:0] ctl_a,
  input  logic [REG_W-1:0] ctl_b,
  output logic [REG_W-1:0] hit_vec
);
  logic [REG_W-1:0] prev;
  logic             prev_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev     <= '0;
      prev_vld <= 1'b0;
    end else begin
      prev     <= line_in;
      prev_vld <= 1'b1;
    end
  end

  logic [REG_W-1:0] rise_w, fall_w;
  assign rise_w = line_in & ~prev;
  assign fall_w = ~line_in & prev;

  generate
    for (genvar g = 0; g < REG_W; g++) begin : g_line
      localparam int B = line_bit(g);
      if (TWO_BIT_MODE) begin : g_two
        localparam int F = field_lsb(g);
        logic [CODE_W-1:0] code;
        if (g < HALF) begin : g_lo
          assign code = ctl_a[F +: CODE_W];
        end else begin : g_hi
          assign code = ctl_b[F +: CODE_W];
        end
        assign hit_vec[B] = prev_vld & edge_hit(edge_sel_e'(code), rise_w[g], fall_w[g]);
      end else begin : g_one
        assign hit_vec[B] = prev_vld & (ctl_a[B] ? fall_w[g] : (rise_w[g] | fall_w[g]));
      end
    end
    if (!TWO_BIT_MODE) begin : g_unused
      logic unused_ctl_b;
      assign unused_ctl_b = ^ctl_b;
    end
  endgenerate

  AST_STABLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    ((line_in ^ prev) == '0) |-> (hit_vec == '0)); // R9
endmodule

// File: rtl/gpio_evt_pend.sv
module gpio_evt_pend
  import gpio_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] set_vec,
  input  logic [REG_W-1:0] clr_vec,
  input  logic [REG_W-1:0] mask,
  output logic [REG_W-1:0] pend,
  output logic             irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr_vec) | set_vec;
  end

  assign irq = |(pend & mask);

  AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec != '0) |=> ((pend & $past(clr_vec & ~set_vec)) == '0)); // R3
  AST_HIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((pend & $past(set_vec)) == $past(set_vec))); // R4
  AST_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(set_vec)) == '0)); // R5
  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> !irq); // R5
endmodule

// File: rtl/gpio_evt_ctrl.sv
module gpio_evt_ctrl
  import gpio_evt_pkg::*;
#(
  parameter bit TWO_BIT_MODE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_W-1:0]  line_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  output logic              irq
);
  logic [REG_W-1:0] mask, ctl_a, ctl_b, clr_vec, hit_vec, pend;

  gpio_evt_regs #(.TWO_BIT_MODE(TWO_BIT_MODE)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .pend(pend), .mask(mask), .ctl_a(ctl_a), .ctl_b(ctl_b),
    .clr_vec(clr_vec), .rd_data(rd_data)
  );

  gpio_evt_detect #(.TWO_BIT_MODE(TWO_BIT_MODE)) u_detect (
    .clk(clk), .rst_n(rst_n), .line_in(line_in),
    .ctl_a(ctl_a), .ctl_b(ctl_b), .hit_vec(hit_vec)
  );

  gpio_evt_pend u_pend (
    .clk(clk), .rst_n(rst_n), .set_vec(hit_vec), .clr_vec(clr_vec),
    .mask(mask), .pend(pend), .irq(irq)
  );

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq); // R5
endmodule

// File: tb/tb_gpio_evt_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_evt_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lines1 = '0, lines2 = '0;
  logic        wr1 = 1'b0, wr2 = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd1, rd2;
  logic        irq1, irq2;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_evt_ctrl #(.TWO_BIT_MODE(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .line_in(lines1), .wr_en(wr1), .addr(addr),
    .wr_data(wdata), .rd_data(rd1), .irq(irq1));
  gpio_evt_ctrl #(.TWO_BIT_MODE(1'b1)) dut_2b (
    .clk(clk), .rst_n(rst_n), .line_in(lines2), .wr_en(wr2), .addr(addr),
    .wr_data(wdata), .rd_data(rd2), .irq(irq2));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(bit sel, logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    if (sel) wr2 = 1'b1; else wr1 = 1'b1;
    @(negedge clk);
    wr1 = 1'b0; wr2 = 1'b0;
  endtask

  task automatic rd(bit sel, logic [7:0] a, output logic [31:0] d);
    addr = a;
    #0.5;
    d = sel ? rd2 : rd1;
  endtask

  task automatic set_line(bit sel, int n, logic v);
    @(negedge clk);
    if (sel) lines2[n] = v; else lines1[n] = v;
    @(negedge clk);
  endtask

  function automatic logic [31:0] bitof(int n);
    return 32'h8000_0000 >> n;
  endfunction

  logic [31:0] d;

  initial begin
    lines1 = 32'h0000_0001;   // line 0 high through reset
    lines2 = 32'h0000_0003;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset values and R9 no event from level high at reset
    rd(0, 8'h0C, d); chk("R9 no event for line high at reset", d, 32'h0);
    rd(1, 8'h0C, d); chk("R9 no event (two-bit) at reset", d, 32'h0);
    rd(0, 8'h10, d); chk("R1 mask reset", d, 32'h0);
    rd(0, 8'h14, d); chk("R1 ctrl reset", d, 32'h0);
    rd(1, 8'h18, d); chk("R1 ctrl2 reset", d, 32'h0);
    chk("R1 irq low", {31'b0, irq1 | irq2}, 32'h0);

    // R8 register readback and ignored offset
    wr(0, 8'h10, 32'hA5A5_0F0F); rd(0, 8'h10, d); chk("R8 mask readback", d, 32'hA5A5_0F0F);
    wr(0, 8'h14, 32'h1234_5678); rd(0, 8'h14, d); chk("R8 ctrl readback", d, 32'h1234_5678);
    wr(0, 8'h18, 32'hFFFF_FFFF); rd(0, 8'h18, d); chk("R8 ctrl2 absent in one-bit mode", d, 32'h0);
    wr(1, 8'h18, 32'hCAFE_F00D); rd(1, 8'h18, d); chk("R8 ctrl2 readback", d, 32'hCAFE_F00D);
    rd(0, 8'h1C, d); chk("R8 unmapped offset reads 0", d, 32'h0);

    // R5 latch while masked, unmask raises irq
    wr(0, 8'h10, 32'h0); wr(0, 8'h14, 32'h0);
    set_line(0, 0, 1'b0);          // falling edge on line 0
    rd(0, 8'h0C, d); chk("R2 line 0 maps to bit 31", d, 32'h8000_0000);
    chk("R5 irq low while masked", {31'b0, irq1}, 32'h0);
    wr(0, 8'h10, 32'h0000_0001);
    chk("R5 irq low with other line unmasked", {31'b0, irq1}, 32'h0);
    wr(0, 8'h10, 32'h8000_0000);
    chk("R5 irq rises on unmask", {31'b0, irq1}, 32'h1);
    // R3 writing zeros keeps, ones clear
    wr(0, 8'h0C, 32'h7FFF_FFFF); rd(0, 8'h0C, d); chk("R3 zero bit keeps event", d, 32'h8000_0000);
    wr(0, 8'h0C, 32'h8000_0000); rd(0, 8'h0C, d); chk("R3 one bit clears event", d, 32'h0);
    chk("R5 irq low after clear", {31'b0, irq1}, 32'h0);

    // R4 same-cycle edge and clear
    set_line(0, 5, 1'b1);
    set_line(0, 6, 1'b1);
    @(negedge clk);
    lines1[5] = 1'b0; addr = 8'h0C; wdata = 32'hFFFF_FFFF; wr1 = 1'b1;
    @(negedge clk);
    wr1 = 1'b0;
    rd(0, 8'h0C, d); chk("R4 new edge beats clear", d, bitof(5));
    wr(0, 8'h0C, 32'hFFFF_FFFF);
    rd(0, 8'h0C, d); chk("R3 clear all", d, 32'h0);
    set_line(0, 6, 1'b0);
    wr(0, 8'h0C, 32'hFFFF_FFFF);
    lines2 = '0;
    repeat (2) @(negedge clk);
    wr(1, 8'h0C, 32'hFFFF_FFFF);

    // R6 sweep one-bit format
    wr(0, 8'h10, 32'hFFFF_FFFF);
    for (int n = 0; n < 32; n++) begin
      for (int cfg = 0; cfg < 2; cfg++) begin
        wr(0, 8'h14, cfg ? bitof(n) : 32'h0);
        set_line(0, n, 1'b1);
        rd(0, 8'h0C, d); chk("R6 rising edge", d, cfg ? 32'h0 : bitof(n));
        chk("R5 irq follows event", {31'b0, irq1}, {31'b0, cfg == 0});
        wr(0, 8'h0C, 32'hFFFF_FFFF);
        set_line(0, n, 1'b0);
        rd(0, 8'h0C, d); chk("R6 falling edge", d, bitof(n));
        wr(0, 8'h0C, 32'hFFFF_FFFF);
      end
    end

    // R7 sweep two-bit format
    wr(1, 8'h10, 32'hFFFF_FFFF);
    for (int n = 0; n < 32; n++) begin
      for (int code = 0; code < 4; code++) begin
        logic [31:0] fld;
        fld = 32'(code) << (30 - 2 * (n % 16));
        wr(1, 8'h14, (n < 16) ? fld : 32'hFFFF_FFFF);
        wr(1, 8'h18, (n < 16) ? 32'hFFFF_FFFF : fld);
        set_line(1, n, 1'b1);
        rd(1, 8'h0C, d);
        chk("R7 rising edge by code", d, (code == 0 || code == 1) ? bitof(n) : 32'h0);
        wr(1, 8'h0C, 32'hFFFF_FFFF);
        set_line(1, n, 1'b0);
        rd(1, 8'h0C, d);
        chk("R7 falling edge by code", d, (code == 0 || code == 2) ? bitof(n) : 32'h0);
        chk("R5 irq two-bit", {31'b0, irq2}, {31'b0, (code == 0 || code == 2)});
        wr(1, 8'h0C, 32'hFFFF_FFFF);
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule